// File: doc/BRIEF.md
# Ping-Pong Video Line Capture Buffer

This block takes 8-bit video samples at the pixel clock, groups every four samples of an active line into one 32-bit word, and drives the write port of a dual-port RAM whose address space is split into two halves. Words are written into one half until it holds a fixed number of lines (25 lines of 160 words by default). The block then emits a one-cycle interrupt, reports which half is complete, and continues writing into the other half. A processor can drain the completed half while the other half fills, so reads and writes never meet in the same half.

When the field indicator changes from odd to even, the block writes half a line of black words once no line is active. Each field then holds a whole number of lines, and every field splits into whole half-buffer transfers. Sync extraction, the RAM array and the reading side sit outside this block.

The control is a three-state machine:
- **IDLE** waits between lines. It moves to **LINE** when `line_valid` rises. If no line is active and a black pad is pending, it moves to **PAD**.
- **LINE** accepts samples. It returns to **IDLE** when `line_valid` falls.
- **PAD** writes the black words, one per clock. It returns to **IDLE** after the last one.

Top module: `video_capture_pingpong`

## Requirements
- R1: A written word holds four accepted samples with the first sample in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24.
- R2: One word is written per four accepted samples, one clock after the fourth sample. The lane count restarts whenever `line_valid` is low, so leftover samples of a line whose length is not a multiple of four are dropped.
- R3: Write `n` since reset goes to address `{half, offset}`, where `half` (the MSB of `mem_addr`) is `(n / HALF_WORDS) % 2` and `offset` (the low bits) is `n % HALF_WORDS`. `HALF_WORDS` is lines per half times words per line (default 4000), and offsets from `HALF_WORDS` up to the end of each half are never written.
- R4: `half_done_irq` is high for exactly one clock, in the same cycle as the write to the last offset of a half, and at no other time.
- R5: `ready_half` takes the index of the half just completed in the `half_done_irq` cycle and holds it until the next completion.
- R6: After a half completes, the next write goes to offset 0 of the other half. No later write targets the half named by `ready_half` until the next completion.
- R7: A 0-to-1 change of `field_even` queues a pad. The pad is written in state PAD once `line_valid` is low: `WORDS_PER_LINE/2` words, each four copies of the black level (0x10 by default), at the next sequential addresses and ahead of the next line's words.
- R8: While `line_valid` is low and no pad is being written, `pix_data` is ignored and `mem_we` stays low.
- R9: Synchronous active-high `rst` returns the address to half 0 offset 0, clears the lane count and any pending pad, holds `mem_we` and `half_done_irq` low, and sets `ready_half` to 0.
- R10: A 1-to-0 change of `field_even` writes no pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_data | input | SAMPLE_W (8) | Video sample |
| line_valid | input | 1 | High while active-line samples are presented |
| field_even | input | 1 | Field indicator, 1 for the even field |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | HALF_AW+1 (13) | RAM write address, MSB selects the half |
| mem_wdata | output | SAMPLE_W*LANES (32) | RAM write data |
| half_done_irq | output | 1 | One-clock pulse when a half is full |
| ready_half | output | 1 | Index of the most recently completed half |

## Verification
The bench runs a reduced configuration with 16 samples per line and 3 lines per half, so that many half crossings occur. Full lines carry distinct arithmetic ramps, which separate lane ordering from line ordering. A constant all-ones line catches stuck data bits, and a six-sample line shows the dropped remainder and the restart of the lane count. Noise presented while `line_valid` is low tests the idle path, and both directions of the field change tell a pad that is written from one that must not be. A reset in the middle of half 1 shows that addressing and `ready_half` restart from half 0 rather than carrying on.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LINE = 2'd1,
        ST_PAD  = 2'd2
    } vcap_state_e;
endpackage

// File: rtl/vcap_packer.sv
`timescale 1ns/1ps
module vcap_packer #(
    parameter int SAMPLE_W = 8,
    parameter int LANES    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_en,
    input  logic                      line_idle,
    input  logic [SAMPLE_W-1:0]       sample,
    output logic                      word_valid,
    output logic [SAMPLE_W*LANES-1:0] word
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    logic [LW-1:0] lane_q;

    always_ff @(posedge clk) begin
        if (rst || line_idle) begin
            lane_q <= '0;
        end else if (sample_en) begin
            lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
        end
    end

    // lower lanes are held, the top lane comes straight from the input
    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        logic [SAMPLE_W-1:0] hold_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q <= '0;
            end else if (sample_en && lane_q == LW'(g)) begin
                hold_q <= sample;
            end
        end
        assign word[g*SAMPLE_W +: SAMPLE_W] = hold_q;
    end

    assign word[(LANES-1)*SAMPLE_W +: SAMPLE_W] = sample;
    assign word_valid = sample_en && (lane_q == LAST_LANE);
endmodule

// File: rtl/vcap_addr_seq.sv
`timescale 1ns/1ps
module vcap_addr_seq #(
    parameter int HALF_AW    = 12,
    parameter int HALF_WORDS = 4000,
    parameter int WORD_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [WORD_W-1:0] wr_word,
    output logic              mem_we,
    output logic [HALF_AW:0]  mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              half_done_irq,
    output logic              ready_half
);
    localparam logic [HALF_AW-1:0] LAST_OFFS = HALF_AW'(HALF_WORDS - 1);

    logic               half_q;
    logic [HALF_AW-1:0] offs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q        <= 1'b0;
            offs_q        <= '0;
            mem_we        <= 1'b0;
            mem_addr      <= '0;
            mem_wdata     <= '0;
            half_done_irq <= 1'b0;
            ready_half    <= 1'b0;
        end else begin
            mem_we        <= wr_req;
            half_done_irq <= 1'b0;
            if (wr_req) begin
                mem_addr  <= {half_q, offs_q};
                mem_wdata <= wr_word;
                if (offs_q == LAST_OFFS) begin
                    offs_q        <= '0;
                    half_q        <= ~half_q;
                    half_done_irq <= 1'b1;
                    ready_half    <= half_q;
                end else begin
                    offs_q <= offs_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/video_capture_pingpong.sv
`timescale 1ns/1ps
module video_capture_pingpong #(
    parameter int                    SAMPLE_W         = 8,
    parameter int                    LANES            = 4,
    parameter int                    SAMPLES_PER_LINE = 640,
    parameter int                    LINES_PER_HALF   = 25,
    parameter int                    HALF_AW          = 12,
    parameter logic [SAMPLE_W-1:0]   BLACK_LEVEL      = 8'h10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SAMPLE_W-1:0]       pix_data,
    input  logic                      line_valid,
    input  logic                      field_even,
    output logic                      mem_we,
    output logic [HALF_AW:0]          mem_addr,
    output logic [SAMPLE_W*LANES-1:0] mem_wdata,
    output logic                      half_done_irq,
    output logic                      ready_half
);
    import vcap_pkg::*;

    localparam int WORD_W         = SAMPLE_W * LANES;
    localparam int WORDS_PER_LINE = SAMPLES_PER_LINE / LANES;
    localparam int HALF_WORDS     = LINES_PER_HALF * WORDS_PER_LINE;
    localparam int PAD_WORDS      = WORDS_PER_LINE / 2;
    localparam int PCW            = $clog2(PAD_WORDS + 1);
    localparam logic [PCW-1:0] PAD_LAST = PCW'(PAD_WORDS - 1);

    vcap_state_e     state_q, state_d;
    logic            field_q;
    logic            pad_pending_q;
    logic [PCW-1:0]  pad_cnt_q;

    logic              sample_en;
    logic              pad_wr;
    logic              pk_valid;
    logic [WORD_W-1:0] pk_word;
    logic              wr_req;
    logic [WORD_W-1:0] wr_word;

    // state register and its bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            field_q       <= 1'b1;
            pad_pending_q <= 1'b0;
            pad_cnt_q     <= '0;
        end else begin
            state_q       <= state_d;
            field_q       <= field_even;
            pad_pending_q <= (pad_pending_q && state_q != ST_PAD) || (field_even && !field_q);
            pad_cnt_q     <= (state_q == ST_PAD) ? pad_cnt_q + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (line_valid)         state_d = ST_LINE;
                else if (pad_pending_q) state_d = ST_PAD;
            end
            ST_LINE: begin
                if (!line_valid)        state_d = ST_IDLE;
            end
            ST_PAD: begin
                if (pad_cnt_q == PAD_LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        sample_en = 1'b0;
        pad_wr    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LINE: sample_en = line_valid;
            ST_PAD:           pad_wr    = 1'b1;
            default:          ;
        endcase
    end

    vcap_packer #(
        .SAMPLE_W (SAMPLE_W),
        .LANES    (LANES)
    ) packer_i (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .line_idle  (!line_valid),
        .sample     (pix_data),
        .word_valid (pk_valid),
        .word       (pk_word)
    );

    assign wr_req  = pad_wr || pk_valid;
    assign wr_word = pad_wr ? {LANES{BLACK_LEVEL}} : pk_word;

    vcap_addr_seq #(
        .HALF_AW    (HALF_AW),
        .HALF_WORDS (HALF_WORDS),
        .WORD_W     (WORD_W)
    ) seq_i (
        .clk           (clk),
        .rst           (rst),
        .wr_req        (wr_req),
        .wr_word       (wr_word),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .half_done_irq (half_done_irq),
        .ready_half    (ready_half)
    );
endmodule

// File: rtl/vcap_checker.sv
`timescale 1ns/1ps
module vcap_checker #(
    parameter int LANES            = 4,
    parameter int SAMPLES_PER_LINE = 640,
    parameter int LINES_PER_HALF   = 25,
    parameter int HALF_AW          = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_we,
    input logic [HALF_AW:0] mem_addr,
    input logic             half_done_irq,
    input logic             ready_half
);
    localparam int HW = LINES_PER_HALF * (SAMPLES_PER_LINE / LANES);
    localparam logic [HALF_AW-1:0] LAST_OFFS = HALF_AW'(HW - 1);

    logic             prev_valid;
    logic             seen_irq;
    logic [HALF_AW:0] prev_addr;
    logic [HALF_AW:0] next_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid <= 1'b0;
            seen_irq   <= 1'b0;
            prev_addr  <= '0;
        end else begin
            if (mem_we) begin
                prev_valid <= 1'b1;
                prev_addr  <= mem_addr;
            end
            if (half_done_irq) seen_irq <= 1'b1;
        end
    end

    always_comb begin
        if (prev_addr[HALF_AW-1:0] == LAST_OFFS)
            next_addr = {~prev_addr[HALF_AW], {HALF_AW{1'b0}}};
        else
            next_addr = prev_addr + 1'b1;
    end

    p_offset_bound_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[HALF_AW-1:0] <= LAST_OFFS);

    p_sequential_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && prev_valid) |-> mem_addr == next_addr);

    p_irq_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        half_done_irq |=> !half_done_irq);

    p_irq_on_last_r4: assert property (@(posedge clk) disable iff (rst)
        half_done_irq |-> (mem_we && mem_addr[HALF_AW-1:0] == LAST_OFFS));

    p_ready_matches_r5: assert property (@(posedge clk) disable iff (rst)
        half_done_irq |-> ready_half == mem_addr[HALF_AW]);

    p_ready_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !half_done_irq |-> $stable(ready_half));

    p_other_half_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !half_done_irq && seen_irq) |-> mem_addr[HALF_AW] != ready_half);
endmodule

bind video_capture_pingpong vcap_checker #(
    .LANES            (LANES),
    .SAMPLES_PER_LINE (SAMPLES_PER_LINE),
    .LINES_PER_HALF   (LINES_PER_HALF),
    .HALF_AW          (HALF_AW)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .half_done_irq (half_done_irq),
    .ready_half    (ready_half)
);

// File: tb/video_capture_pingpong_tb_top.sv
`timescale 1ns/1ps
module video_capture_pingpong_tb_top;
    localparam int SPL   = 16;
    localparam int LPH   = 3;
    localparam int HAW   = 4;
    localparam int WPL   = SPL / 4;
    localparam int HW    = LPH * WPL;
    localparam int PADW  = WPL / 2;
    localparam logic [7:0] BLACK = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pix_data = '0;
    logic        line_valid = 1'b0;
    logic        field_even = 1'b0;
    logic        mem_we;
    logic [HAW:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        half_done_irq;
    logic        ready_half;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int wr_idx   = 0;
    int rd_idx   = 0;
    logic        exp_ready = 1'b0;
    logic [31:0] exp_word [0:255];
    string       exp_tag  [0:255];

    always #2.5 clk = ~clk;

    video_capture_pingpong #(
        .SAMPLES_PER_LINE (SPL),
        .LINES_PER_HALF   (LPH),
        .HALF_AW          (HAW),
        .BLACK_LEVEL      (BLACK)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .pix_data      (pix_data),
        .line_valid    (line_valid),
        .field_even    (field_even),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .half_done_irq (half_done_irq),
        .ready_half    (ready_half)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input string tag);
        exp_word[wr_idx] = w;
        exp_tag[wr_idx]  = tag;
        wr_idx++;
    endtask

    function automatic logic [7:0] sval(input int id, input int i);
        if (id == 90) return 8'hFF;
        return 8'((id * 37 + i * 5 + 1) & 255);
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            line_valid = 1'b0;
        end
    endtask

    task automatic send_line(input int id, input int nsamp, input string tag);
        logic [31:0] acc;
        acc = '0;
        for (int i = 0; i < nsamp; i++) begin
            @(negedge clk);
            line_valid = 1'b1;
            pix_data   = sval(id, i);
            acc[8*(i%4) +: 8] = pix_data;
            if (i % 4 == 3) push(acc, tag);
        end
        @(negedge clk);
        line_valid = 1'b0;
        idle(3);
    endtask

    // scoreboard on the write port, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (rd_idx >= wr_idx) begin
                    chk("R8 unexpected write", {31'd0, mem_we}, 64'd0);
                end else begin
                    int n, h, o;
                    n = rd_idx;
                    h = (n / HW) % 2;
                    o = n % HW;
                    if (o == 0 && n > 0) chk("R6 switch to other half", mem_addr, {h[0], HAW'(0)});
                    else chk("R3 address", mem_addr, {h[0], HAW'(o)});
                    chk(exp_tag[n], mem_wdata, exp_word[n]);
                    if (o == HW - 1) begin
                        exp_ready = h[0];
                        chk("R4 irq on last word", half_done_irq, 1);
                    end else begin
                        chk("R4 no irq mid-half", half_done_irq, 0);
                    end
                    chk("R5 ready_half", ready_half, exp_ready);
                    rd_idx++;
                end
            end else if (half_done_irq) begin
                chk("R4 irq without write", half_done_irq, 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", rd_idx, wr_idx);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset mem_we", mem_we, 0);
        chk("R9 reset irq", half_done_irq, 0);
        chk("R9 reset ready_half", ready_half, 0);

        // five full lines: crosses from half 0 into half 1 (R1, R3, R4, R5, R6)
        for (int l = 0; l < 5; l++) send_line(l + 1, SPL, "R1 packed data");

        // odd to even: pad of black words ahead of the next line (R7)
        @(negedge clk);
        field_even = 1'b1;
        for (int p = 0; p < PADW; p++) push({4{BLACK}}, "R7 black pad");
        idle(6);
        send_line(10, SPL, "R1 after pad");
        send_line(11, SPL, "R1 after pad");

        // six samples: one word, remainder dropped, next line restarts lanes (R2)
        send_line(20, 6, "R2 partial line");
        send_line(21, SPL, "R2 lane restart");

        // noise while line_valid is low must not write (R8)
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            line_valid = 1'b0;
            pix_data   = 8'(k * 13 + 7);
        end

        // even to odd: no pad (R10)
        @(negedge clk);
        field_even = 1'b0;
        idle(8);
        send_line(90, SPL, "R10 no pad, constant line");
        send_line(30, SPL, "R1 ramp line");
        idle(4);
        chk("R2 all words written", rd_idx, wr_idx);

        // reset in the middle of a half (R9)
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        wr_idx = 0;
        rd_idx = 0;
        exp_ready = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R9 mid reset ready_half", ready_half, 0);
        chk("R9 mid reset mem_we", mem_we, 0);
        for (int l = 0; l < 7; l++) send_line(40 + l, SPL, "R9 restart data");
        idle(4);
        chk("R2 all words after reset", rd_idx, wr_idx);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule